// File: doc/BRIEF.md
# Credit-Gated Stream Stage

This block is a valid/ready pass-through stage. A separate credit counter decides whether a transfer may complete. A one-cycle pulse on `credit_add` grants one credit, and every beat that completes on the output side spends one. While no credit is held the path is closed: `out_valid` and `in_ready` both stay low, so neither side sees a handshake. While credits are held the stage is transparent. Valid, ready and data pass straight through with no register on the path.

The stage exposes the live credit count, an empty flag and a full flag. A producer of credits can hold off while the count is full. Other logic can wait on the empty flag to learn that every outstanding beat has drained. The stage raises `credit_refused` in any cycle where a grant is dropped because the counter is already full. A synchronous clear returns the count to zero.

Back-pressure rules:
- The upstream side sees `in_ready` only when `out_ready` is high and a credit is held.
- The downstream side sees `out_valid` only when `in_valid` is high and a credit is held.
- A beat completes when `out_valid` and `out_ready` are both high in the same cycle.

Top module: `credit_gate_stage`

## Requirements
- R1: While `clear` is high at a rising edge, the count becomes 0 at that edge, whatever the other inputs are. The empty flag then reads 1 and the full flag reads 0.
- R2: A cycle with `credit_add` high and no completed output beat raises the count by one, provided the count is below `MAX_CREDITS`.
- R3: A cycle with a completed output beat (`out_valid` and `out_ready` both high) and `credit_add` low lowers the count by one.
- R4: A cycle with both `credit_add` high and a completed output beat leaves the count unchanged, and `credit_refused` stays low, even when the count is at `MAX_CREDITS`.
- R5: While the count is 0, `out_valid` and `in_ready` are both 0, whatever `in_valid` and `out_ready` are.
- R6: While the count is nonzero, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, in the same cycle.
- R7: `out_data` always equals `in_data`, bit for bit.
- R8: At count `MAX_CREDITS`, a `credit_add` cycle with no completed beat has two effects. `credit_refused` reads 1 in that cycle, and the count stays at `MAX_CREDITS`. In every other cycle `credit_refused` reads 0.
- R9: `credit_count` shows the registered count. `credits_empty` is 1 exactly when that count is 0, and `credits_full` is 1 exactly when it equals `MAX_CREDITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clear | input | 1 | Synchronous clear, active high |
| credit_add | input | 1 | Grant one credit this cycle |
| credit_refused | output | 1 | Grant dropped because the counter is full |
| credit_count | output | CNT_W | Current credit count |
| credits_empty | output | 1 | Count is zero |
| credits_full | output | 1 | Count is at MAX_CREDITS |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Stage accepts the upstream beat |
| in_data | input | DATA_W | Upstream beat payload |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | DATA_W | Downstream beat payload |

## Verification
Assertions check every cycle against the previous one:
- the count step for each combination of grant and completed beat, including the saturated refusal;
- the closed path at zero credits;
- the transparency of valid and ready while credits are held.

The bench's scenarios are needed for the rest:
- long runs of random grants and beats against a reference count, showing that the count, the flags and the data agree over many cycles;
- fill to the limit, then a grant with and without a simultaneous beat, then a drain to zero;
- a clear issued while traffic is in flight.

// File: rtl/credit_gate_pkg.sv
package credit_gate_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_UP     = 2'd1,
    CNT_DOWN   = 2'd2,
    CNT_REFUSE = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cg_step_decode.sv
module cg_step_decode
  import credit_gate_pkg::*;
(
  input  logic    grant,
  input  logic    spend,
  input  logic    at_limit,
  output cnt_op_e op
);
  always_comb begin
    unique case ({grant, spend})
      2'b10:   op = at_limit ? CNT_REFUSE : CNT_UP;
      2'b01:   op = CNT_DOWN;
      default: op = CNT_HOLD;
    endcase
  end
endmodule

// File: rtl/cg_credit_counter.sv
module cg_credit_counter
  import credit_gate_pkg::*;
#(
  parameter int MAX_CREDITS = 255,
  localparam int CNT_W = $clog2(MAX_CREDITS + 1)
) (
  input  logic             clk,
  input  logic             clear,
  input  cnt_op_e          op,
  output logic [CNT_W-1:0] count,
  output logic             is_zero,
  output logic             is_max
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_CREDITS);

  always_ff @(posedge clk) begin
    if (clear) begin
      count <= '0;
    end else begin
      unique case (op)
        CNT_UP:   count <= count + 1'b1;
        CNT_DOWN: count <= count - 1'b1;
        default:  count <= count;
      endcase
    end
  end

  assign is_zero = (count == '0);
  assign is_max  = (count == LIMIT);

  a_r1_clear_zero: assert property (@(posedge clk) clear |=> count == '0);
  a_r2_step_up: assert property (@(posedge clk) disable iff (clear)
    op == CNT_UP |=> count == $past(count) + 1'b1);
  a_r3_step_down: assert property (@(posedge clk) disable iff (clear)
    op == CNT_DOWN |=> count == $past(count) - 1'b1);
  a_r8_saturate: assert property (@(posedge clk) disable iff (clear)
    op == CNT_REFUSE |=> count == LIMIT);
  a_r9_in_range: assert property (@(posedge clk) disable iff (clear)
    count <= LIMIT);
endmodule

// File: rtl/cg_flow_gate.sv
module cg_flow_gate #(
  parameter int DATA_W = 32
) (
  input  logic              open_path,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic              beat_done
);
  assign dn_valid  = up_valid & open_path;
  assign up_ready  = dn_ready & open_path;
  assign dn_data   = up_data;
  assign beat_done = dn_valid & dn_ready;

  always_comb begin
    if (!open_path) a_r5_closed: assert (!dn_valid && !up_ready);
  end
endmodule

// File: rtl/credit_gate_stage.sv
module credit_gate_stage
  import credit_gate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAX_CREDITS = 255,
  localparam int CNT_W = $clog2(MAX_CREDITS + 1)
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              credit_add,
  output logic              credit_refused,
  output logic [CNT_W-1:0]  credit_count,
  output logic              credits_empty,
  output logic              credits_full,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  cnt_op_e op;
  logic    beat;

  cg_flow_gate #(.DATA_W(DATA_W)) u_gate (
    .open_path (!credits_empty),
    .up_valid  (in_valid),
    .up_ready  (in_ready),
    .up_data   (in_data),
    .dn_valid  (out_valid),
    .dn_ready  (out_ready),
    .dn_data   (out_data),
    .beat_done (beat)
  );

  cg_step_decode u_dec (
    .grant    (credit_add),
    .spend    (beat),
    .at_limit (credits_full),
    .op       (op)
  );

  cg_credit_counter #(.MAX_CREDITS(MAX_CREDITS)) u_cnt (
    .clk     (clk),
    .clear   (clear),
    .op      (op),
    .count   (credit_count),
    .is_zero (credits_empty),
    .is_max  (credits_full)
  );

  assign credit_refused = (op == CNT_REFUSE);

  a_r4_both_hold: assert property (@(posedge clk) disable iff (clear)
    credit_add && out_valid && out_ready |=> $stable(credit_count));
  a_r4_no_refuse: assert property (@(posedge clk) disable iff (clear)
    out_valid && out_ready |-> !credit_refused);
  a_r6_transparent: assert property (@(posedge clk) disable iff (clear)
    !credits_empty |-> (out_valid == in_valid) && (in_ready == out_ready));
  a_r7_data_through: assert property (@(posedge clk) disable iff (clear)
    out_data == in_data);
endmodule

// File: tb/credit_gate_stage_test.sv
module credit_gate_stage_test;
  localparam int DW = 16;
  localparam int MAXC = 6;
  localparam int CW = $clog2(MAXC + 1);

  logic clk = 0, clear = 1, credit_add = 0, in_valid = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic credit_refused, credits_empty, credits_full, in_ready, out_valid;
  logic [CW-1:0] credit_count;
  logic [DW-1:0] out_data;
  int vectors = 0, errors = 0;
  int model = 0;

  always #2 clk = ~clk;

  credit_gate_stage #(.DATA_W(DW), .MAX_CREDITS(MAXC)) uut (.*);

  function automatic int next_count(int c, bit add, bit iv, bit ordy);
    bit take = iv && ordy && (c != 0);
    if (add && !take) return (c == MAXC) ? c : c + 1;
    if (take && !add) return c - 1;
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, check combinational outputs, then clock
  task automatic step(bit clr, bit add, bit iv, bit ordy, logic [DW-1:0] d);
    bit open;
    @(negedge clk);
    clear = clr; credit_add = add; in_valid = iv; out_ready = ordy; in_data = d;
    #1;
    open = (model != 0);
    chk("R9 count", credit_count, model);
    chk("R9 empty", credits_empty, model == 0);
    chk("R9 full", credits_full, model == MAXC);
    chk(open ? "R6 out_valid" : "R5 out_valid", out_valid, iv && open);
    chk(open ? "R6 in_ready" : "R5 in_ready", in_ready, ordy && open);
    chk("R7 data", out_data, d);
    if (!clr) begin
      if (add && model == MAXC && iv && ordy) chk("R4 refuse", credit_refused, 0);
      else chk("R8 refuse", credit_refused, add && model == MAXC && !(iv && ordy && open));
    end
    @(posedge clk);
    model = clr ? 0 : next_count(model, add, iv, ordy);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(1, 1, 1, 1, 16'h1111);            // R1 clear dominates
    step(0, 0, 1, 1, 16'hA5A5);            // R5 closed at zero
    chk("R1 empty after clear", credits_empty, 1);
    for (int i = 0; i < MAXC; i++) step(0, 1, 0, 0, 16'(i));   // R2 fill
    step(0, 1, 0, 1, 16'h2222);            // R8 refused at max
    step(0, 1, 1, 1, 16'h3333);            // R4 both at max: hold, no refuse
    step(0, 0, 1, 0, 16'h4444);            // R6 stalled downstream
    for (int i = 0; i < MAXC; i++) step(0, 0, 1, 1, 16'(i * 7)); // R3 drain
    step(0, 0, 1, 1, 16'h5555);            // R5 closed again
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 16'h0);
    step(1, 0, 1, 1, 16'h6666);            // R1 clear mid-traffic
    for (int i = 0; i < 4000; i++)
      step(($urandom % 200) == 0, $urandom % 2, ($urandom % 4) != 0,
           $urandom % 2, 16'($urandom));
    step(0, 0, 0, 0, 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule